// File: doc/BRIEF.md
# System configuration register bank

A block of eleven 32-bit configuration registers reached through a simple word-addressed request bus. Each register bit follows one of several access policies: plain read-write, reserved (always zero), set-only (once a one is written it sticks until reset), clear-only (once a zero is written it sticks until reset), and a hardware-raised flag that software can only clear by writing a one. Four of the registers are interrupt source selectors. Their 4-bit fields also steer a multiplexer inside the block. The multiplexer maps 64 GPIO level inputs, arranged as four ports of 16 pins, onto 16 interrupt lines.

Requests arrive on a valid-qualified bus with no back-pressure: the bank accepts a request in every cycle where `req_valid` is high. A read returns its data with `rsp_valid` one cycle later. A write completes at the accepting edge and produces no response. The interrupt lines are combinational from the GPIO inputs and the current selector state. A selector write therefore takes effect on the lines from the edge that accepts it.

Top module: `sysconf_regbank`

## Requirements
- R1: After reset, the register at byte offset 0x04 (config1) reads 0x7C000001 and every other register reads 0. The offsets are 0x00 remap, 0x04 config1, 0x08/0x0C/0x10/0x14 source-select 0..3, 0x18 status, 0x1C config2, 0x20 protect-A, 0x24 key, 0x28 protect-B.
- R2: Writable bits take the written value and all other bits read 0. The writable bits are: remap bits 2..0 and 8; config1 bits 31..26, 23..16 and 8; key bits 7..0; each source-select register bits 15..0.
- R3: Config1 bit 0 is clear-only. A write of 0 clears it, and it stays 0 until reset whatever is written later.
- R4: Config2 bits 3..0 are set-only. A written 1 stays 1 until reset.
- R5: Config2 bit 8 is set by a high `hw_flag_set` and cleared by a write with bit 8 = 1. A write never sets it. If the set and the clear fall in the same cycle, the set wins.
- R6: All 32 bits of protect-A and protect-B are set-only and return to 0 only on reset.
- R7: A read of a word offset at or beyond 0x2C returns 0. A write there changes no register.
- R8: A read accepted at an edge raises `rsp_valid` with the data for exactly the following cycle. A write raises no `rsp_valid`.
- R9: Line n carries `gpio_in[f*16+n]`, where f is its 4-bit selector field for f in 0..3. Field k of source-select register j sits at bits 4k+3..4k and drives line 4j+k. The reset value f=0 selects port A.
- R10: A selector field above 3 holds its line low.
- R11: The status register reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, bits 1..0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| hw_flag_set | input | 1 | Raises config2 bit 8 |
| gpio_in | input | 64 | GPIO levels, index port*16+pin |
| exti_line | output | 16 | Interrupt line outputs |

## Verification
The bench first writes ones into every reserved bit. A design that let a reserved bit latch would read back nonzero. It then probes the sticky policies across two writes. A set-only bit wrongly built as read-write, or a clear-only bit that can be re-armed, shows up in the second read, and a reset pulse at the end must clear them. The flag bit is tested by writing ones without a hardware event and with a hardware event in the same cycle, which catches inverted priority or a write-one-sets bug. Selector fields that point at ports B, C, D and at a value above 3 catch wrong port strides, swapped field order, and a line that follows a stray pin.

// File: rtl/sysconf_pkg.sv
package sysconf_pkg;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned NUM_REGS       = 11;
  localparam int unsigned LINES          = 16;
  localparam int unsigned PORTS          = 4;
  localparam int unsigned SEL_W          = 4;
  localparam int unsigned FIELDS_PER_REG = 4;
  localparam int unsigned NUM_SEL_REGS   = LINES / FIELDS_PER_REG;
  localparam int unsigned GPIO_W         = PORTS * LINES;
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'((64'd1 << (SEL_W * FIELDS_PER_REG)) - 1);

  localparam int IDX_REMAP = 0;
  localparam int IDX_CFG1  = 1;
  localparam int IDX_SEL0  = 2;
  localparam int IDX_STAT  = 6;
  localparam int IDX_CFG2  = 7;
  localparam int IDX_PROTA = 8;
  localparam int IDX_KEY   = 9;
  localparam int IDX_PROTB = 10;

  typedef struct packed {
    logic [DATA_W-1:0] rst;
    logic [DATA_W-1:0] rw;
    logic [DATA_W-1:0] so;
    logic [DATA_W-1:0] co;
    logic [DATA_W-1:0] w1c;
  } reg_policy_t;

  function automatic reg_policy_t reg_policy(input int idx);
    reg_policy_t p;
    p = '0;
    case (idx)
      IDX_REMAP: p.rw = 32'h0000_0107;
      IDX_CFG1: begin
        p.rw  = 32'hFCFF_0100;
        p.co  = 32'h0000_0001;
        p.rst = 32'h7C00_0001;
      end
      IDX_CFG2: begin
        p.so  = 32'h0000_000F;
        p.w1c = 32'h0000_0100;
      end
      IDX_PROTA, IDX_PROTB: p.so = '1;
      IDX_KEY: p.rw = 32'h0000_00FF;
      default: if (idx >= IDX_SEL0 && idx < IDX_SEL0 + int'(NUM_SEL_REGS)) p.rw = SEL_MASK;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sysconf_regfile.sv
module sysconf_regfile
  import sysconf_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             flag_set,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);
  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
    localparam reg_policy_t P = reg_policy(g);
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] hw;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    if (P.w1c != '0) begin : g_hw
      assign hw = flag_set ? P.w1c : '0;
    end else begin : g_nohw
      assign hw = '0;
    end

    always_comb begin
      if (hit)
        nxt = (wr_data & P.rw)
            | ((r | wr_data) & P.so)
            | (r & wr_data & P.co)
            | (r & ~wr_data & P.w1c);
      else
        nxt = r;
      nxt = nxt | hw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= P.rst;
      else        r <= nxt;
    end

    assign q[g] = r;
  end
endmodule

// File: rtl/sysconf_rdmux.sv
module sysconf_rdmux
  import sysconf_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]                idx,
  output logic [DATA_W-1:0]               data
);
  always_comb begin
    data = '0;
    for (int r = 0; r < int'(NUM_REGS); r++)
      if (idx == IDX_W'(r)) data = regs[r];
  end
endmodule

// File: rtl/sysconf_linemux.sv
module sysconf_linemux
  import sysconf_pkg::*;
(
  input  logic [GPIO_W-1:0]      gpio,
  input  logic [LINES*SEL_W-1:0] sel,
  output logic [LINES-1:0]       line
);
  for (genvar n = 0; n < int'(LINES); n++) begin : g_line
    logic [SEL_W-1:0] field;
    logic             bit_out;
    assign field = sel[n*SEL_W +: SEL_W];
    always_comb begin
      bit_out = 1'b0;
      for (int p = 0; p < int'(PORTS); p++)
        if (field == SEL_W'(p)) bit_out = gpio[p*LINES + n];
    end
    assign line[n] = bit_out;
  end
endmodule

// File: rtl/sysconf_regbank.sv
module sysconf_regbank
  import sysconf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              hw_flag_set,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [LINES-1:0]  exti_line
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]                word_idx;
  logic                            mapped;
  logic [1:0]                      unused_byte_lane;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0]               rd_data;
  logic [LINES*SEL_W-1:0]          sel_flat;

  assign word_idx         = req_addr[ADDR_W-1:2];
  assign unused_byte_lane = req_addr[1:0];
  assign mapped           = word_idx < IDX_W'(NUM_REGS);

  sysconf_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (req_valid && req_write && mapped),
    .wr_idx   (word_idx),
    .wr_data  (req_wdata),
    .flag_set (hw_flag_set),
    .q        (reg_q)
  );

  sysconf_rdmux #(.IDX_W(IDX_W)) u_rdmux (
    .regs (reg_q),
    .idx  (word_idx),
    .data (rd_data)
  );

  for (genvar s = 0; s < int'(NUM_SEL_REGS); s++) begin : g_sel
    localparam int unsigned SW = SEL_W * FIELDS_PER_REG;
    assign sel_flat[s*SW +: SW] = reg_q[IDX_SEL0 + s][SW-1:0];
  end

  sysconf_linemux u_lines (
    .gpio (gpio_in),
    .sel  (sel_flat),
    .line (exti_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_data : '0;
    end
  end
endmodule

// File: rtl/sysconf_checker.sv
module sysconf_checker
  import sysconf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_write,
  input logic [ADDR_W-1:0]               req_addr,
  input logic                            rsp_valid,
  input logic [DATA_W-1:0]               rsp_rdata,
  input logic                            hw_flag_set,
  input logic [GPIO_W-1:0]               gpio_in,
  input logic [LINES-1:0]                exti_line,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input logic [LINES*SEL_W-1:0]          sel
);
  logic rd_req;
  logic rd_unmapped;
  assign rd_req      = req_valid && !req_write;
  assign rd_unmapped = rd_req && (req_addr[ADDR_W-1:2] >= (ADDR_W-2)'(NUM_REGS));

  assert_rsp_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  assert_no_rsp_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (rsp_rdata == '0));
  assert_clear_only_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[IDX_CFG1][0] |=> !regs[IDX_CFG1][0]);
  assert_set_only_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[IDX_CFG2][3:0] & ~$past(regs[IDX_CFG2][3:0])) == (regs[IDX_CFG2][3:0] ^ $past(regs[IDX_CFG2][3:0])));
  assert_flag_not_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs[IDX_CFG2][8] && !hw_flag_set) |=> !regs[IDX_CFG2][8]);
  assert_flag_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_flag_set |=> regs[IDX_CFG2][8]);
  assert_protect_a_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(regs[IDX_PROTA]) & ~regs[IDX_PROTA]) == '0);
  assert_protect_b_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(regs[IDX_PROTB]) & ~regs[IDX_PROTB]) == '0);
  assert_status_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    regs[IDX_STAT] == '0);

  for (genvar n = 0; n < int'(LINES); n++) begin : g_line_chk
    assert_port_a_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[n*SEL_W +: SEL_W] == '0) |-> (exti_line[n] == gpio_in[n]));
    assert_line_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[n*SEL_W +: SEL_W] > SEL_W'(PORTS - 1)) |-> !exti_line[n]);
  end
endmodule

bind sysconf_regbank sysconf_checker #(.ADDR_W(ADDR_W)) u_sysconf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .hw_flag_set (hw_flag_set),
  .gpio_in     (gpio_in),
  .exti_line   (exti_line),
  .regs        (reg_q),
  .sel         (sel_flat)
);

// File: tb/test_sysconf_regbank.sv
`timescale 1ns/1ps
module test_sysconf_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        hw_flag_set = 1'b0;
  logic [63:0] gpio_in = '0;
  logic [15:0] exti_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysconf_regbank #(.ADDR_W(8)) i_sysconf_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .hw_flag_set(hw_flag_set), .gpio_in(gpio_in),
    .exti_line(exti_line)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m [11];
  logic        exp_rv;
  logic [31:0] exp_rd;

  function automatic logic [31:0] apply_wr(input int idx, input logic [31:0] old, input logic [31:0] wd);
    case (idx)
      0:       return wd & 32'h107;
      1:       return (wd & 32'hFCFF0100) | (old & wd & 32'h1);
      2,3,4,5: return wd & 32'hFFFF;
      7:       return ((old | wd) & 32'hF) | (old & ~wd & 32'h100);
      8,10:    return old | wd;
      9:       return wd & 32'hFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] model_lines();
    logic [15:0] l;
    for (int n = 0; n < 16; n++) begin
      int f;
      f = int'((m[2 + n/4] >> (4*(n%4))) & 32'hF);
      l[n] = (f < 4) ? gpio_in[f*16 + n] : 1'b0;
    end
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 11; i++) m[i] = 32'h0;
      m[1] = 32'h7C000001;
      exp_rv = 1'b0;
      exp_rd = 32'h0;
    end else begin
      int widx;
      widx = int'(req_addr >> 2);
      exp_rv = req_valid && !req_write;
      exp_rd = (exp_rv && widx < 11) ? m[widx] : 32'h0;
      if (req_valid && req_write && widx < 11) m[widx] = apply_wr(widx, m[widx], req_wdata);
      if (hw_flag_set) m[7] = m[7] | 32'h100;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 model rsp_valid", 64'(rsp_valid), 64'(exp_rv));
      if (exp_rv) chk("R2/R7 model read data", 64'(rsp_rdata), 64'(exp_rd));
      chk("R9/R10 model lines", 64'(exti_line), 64'(model_lines()));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic flag = 1'b0);
    @(posedge clk); #2;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; hw_flag_set = flag;
    @(posedge clk); #2;
    req_valid = 0; req_write = 0; hw_flag_set = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #2;
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #2;
    req_valid = 0;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(tag, 64'(rsp_rdata), 64'(e));
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst_n = 0;
    repeat (2) @(posedge clk);
    #2; rst_n = 1;
  endtask

  task automatic lines_expect(input logic [63:0] g, input logic [15:0] e, input string tag);
    @(posedge clk); #2; gpio_in = g;
    #1 chk(tag, 64'(exti_line), 64'(e));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset values
    rd_expect(8'h00, 32'h0, "R1 remap");
    rd_expect(8'h04, 32'h7C000001, "R1 config1");
    for (int a = 8; a <= 8'h28; a += 4) rd_expect(8'(a), 32'h0, "R1 other");
    @(posedge clk); #2;
    chk("R8 no rsp when idle", 64'(rsp_valid), 64'd0);
    // R2 reserved bits stay zero
    wr(8'h00, 32'hFFFFFEF8); rd_expect(8'h00, 32'h0, "R2 remap reserved");
    wr(8'h04, 32'h7F00FEFF); rd_expect(8'h04, 32'h7C000001, "R2 config1 reserved");
    wr(8'h08, 32'hFFFF0000); rd_expect(8'h08, 32'h0, "R2 select reserved");
    wr(8'h24, 32'hFFFFFF00); rd_expect(8'h24, 32'h0, "R2 key reserved");
    // R2 set and clear
    wr(8'h00, 32'h107); rd_expect(8'h00, 32'h107, "R2 remap set");
    wr(8'h04, 32'hFCFF0101); rd_expect(8'h04, 32'hFCFF0101, "R2 config1 set");
    wr(8'h04, 32'h1); rd_expect(8'h04, 32'h1, "R2 config1 clear");
    wr(8'h14, 32'hFFFF); rd_expect(8'h14, 32'hFFFF, "R2 select3 set");
    wr(8'h14, 32'h0); rd_expect(8'h14, 32'h0, "R2 select3 clear");
    wr(8'h24, 32'hFF); rd_expect(8'h24, 32'hFF, "R2 key set");
    // R11 status
    wr(8'h18, 32'hFFFFFFFF); rd_expect(8'h18, 32'h0, "R11 status ignores write");
    // R5 flag
    wr(8'h1C, 32'h100); rd_expect(8'h1C, 32'h0, "R5 write one does not set");
    @(posedge clk); #2 hw_flag_set = 1; @(posedge clk); #2 hw_flag_set = 0;
    rd_expect(8'h1C, 32'h100, "R5 hardware set");
    wr(8'h1C, 32'h0); rd_expect(8'h1C, 32'h100, "R5 write zero keeps flag");
    wr(8'h1C, 32'h100, 1'b1); rd_expect(8'h1C, 32'h100, "R5 set wins over clear");
    wr(8'h1C, 32'h100); rd_expect(8'h1C, 32'h0, "R5 write one clears");
    // R4 set-only
    wr(8'h1C, 32'h5); wr(8'h1C, 32'hA); wr(8'h1C, 32'h0);
    rd_expect(8'h1C, 32'hF, "R4 set-only bits stick");
    // R6 protect registers
    wr(8'h20, 32'hA5A5A5A5); wr(8'h20, 32'h0); rd_expect(8'h20, 32'hA5A5A5A5, "R6 protect-A sticky");
    wr(8'h28, 32'hFFFFFFFF); wr(8'h28, 32'h0); rd_expect(8'h28, 32'hFFFFFFFF, "R6 protect-B sticky");
    // R3 clear-only
    wr(8'h04, 32'h0); wr(8'h04, 32'h1); rd_expect(8'h04, 32'h0, "R3 clear-only stays clear");
    // R7 unmapped
    wr(8'h2C, 32'hFFFFFFFF); rd_expect(8'h2C, 32'h0, "R7 unmapped read");
    wr(8'hFC, 32'h12345678); rd_expect(8'hFC, 32'h0, "R7 top offset read");
    rd_expect(8'h24, 32'hFF, "R7 key untouched by unmapped write");
    // R9 default port A
    lines_expect(64'h0000_0000_0000_8001, 16'h8001, "R9 port A default");
    lines_expect(64'h0000_0000_FFFF_0000, 16'h0000, "R9 port B ignored by default");
    // R9/R10 selector fields: line0=B, line1=C, line2=D, line3=invalid
    wr(8'h08, 32'h0000F321);
    lines_expect(64'h0000_0000_0001_0000, 16'h0001, "R9 line0 from port B");
    lines_expect(64'h0000_0000_0000_0001, 16'h0000, "R9 port A pin0 ignored");
    lines_expect(64'h0000_0002_0000_0000, 16'h0002, "R9 line1 from port C");
    lines_expect(64'h0004_0000_0000_0000, 16'h0004, "R9 line2 from port D");
    lines_expect(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFF7, "R10 invalid field low");
    // Random sweep against the model
    for (int i = 0; i < 300; i++) begin
      if (i % 10 == 0) wr(8'(8 + 4*($urandom % 4)), $urandom);
      @(posedge clk); #2 gpio_in = {$urandom, $urandom};
    end
    gpio_in = '0;
    // R6/R3 reset clears sticky state
    do_reset();
    rd_expect(8'h20, 32'h0, "R6 reset clears protect-A");
    rd_expect(8'h04, 32'h7C000001, "R3 reset restores bit0");
    rd_expect(8'h1C, 32'h0, "R4 reset clears set-only");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule